// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store of 64 words held in registers, addressed by a 6-bit top-of-stack pointer. A caller asks for a push by raising `push_i` with the word on `data_i`. It asks for a pop by raising `pop_i`, and the top word comes back on `data_o` one cycle later together with a one-cycle `data_valid_o` pulse. Two flags report whether the stack is full or empty. Any request the stack cannot honour leaves every piece of state unchanged and produces a one-cycle `error_o` strobe.

A push first advances the pointer and then writes at the new pointer value. A pop reads at the current pointer and then steps the pointer back. Starting from a pointer of zero, the first push therefore fills slot 1. The pointer wraps to zero on the 64th push, which sets the full flag, so slot 0 is the last slot to be filled. A pop that brings the pointer back to zero sets the empty flag. The pointer is brought out on `sp_o` so that a caller can observe the position of the top of the stack.

Top module: `reg_stack`

## Requirements
- R1: After reset, `sp_o` is 0, `empty_o` is 1, and `full_o`, `error_o` and `data_valid_o` are 0.
- R2: A push while not full and without a pop adds 1 to `sp_o` (modulo 64), stores `data_i` at the new pointer value, and clears `empty_o` one cycle after the request.
- R3: A push whose increment wraps `sp_o` to 0 sets `full_o`. From reset, this happens on the 64th accepted push.
- R4: A pop while not empty and without a push drives the word at the current pointer on `data_o` one cycle later with `data_valid_o` high. The same pop subtracts 1 from `sp_o` and clears `full_o`.
- R5: A pop whose decrement brings `sp_o` to 0 sets `empty_o`.
- R6: Pops return words in the reverse of the order in which they were pushed, across the full depth of 64.
- R7: A push while `full_o` is 1 is ignored: `sp_o`, the flags and the stored words are unchanged, and `error_o` is 1 for one cycle.
- R8: A pop while `empty_o` is 1 is ignored: no `data_valid_o`, `sp_o` and the flags are unchanged, and `error_o` is 1 for one cycle.
- R9: When push and pop are requested in the same cycle, the stack changes nothing (pointer, flags, contents) and `error_o` is 1 for one cycle.
- R10: `error_o` and `data_valid_o` are never high together. Both are low after a cycle with no request. `data_o` holds the last popped word until the next accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| data_i | input | DATA_W | Word to push |
| data_o | output | DATA_W | Last popped word |
| data_valid_o | output | 1 | One-cycle pulse: `data_o` carries a new popped word |
| sp_o | output | log2(DEPTH) | Top-of-stack pointer |
| full_o | output | 1 | Stack holds DEPTH words |
| empty_o | output | 1 | Stack holds no words |
| error_o | output | 1 | One-cycle pulse: the previous request was refused |

## Verification
The hardest state to reach is the wrapped, completely full stack, in which slot 0 holds the newest word and a further push must be refused. The stimulus reaches it with 64 back-to-back pushes of distinct words. It then tries a push while full and a simultaneous push and pop while full. Finally it pops all 64 words, which shows that the refused requests corrupted no slot and that the empty flag returns only on the last pop.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    // Outcome of one cycle's request, resolved before any state changes
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PUSH   = 2'd1,
        OP_POP    = 2'd2,
        OP_REJECT = 2'd3
    } stk_op_e;
endpackage

// File: rtl/rstk_decode.sv
module rstk_decode
    import rstk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    full_i,
    input  logic    empty_i,
    output stk_op_e op_o
);
    always_comb begin
        if (push_i && pop_i) begin
            op_o = OP_REJECT;
        end else if (push_i) begin
            op_o = full_i ? OP_REJECT : OP_PUSH;
        end else if (pop_i) begin
            op_o = empty_i ? OP_REJECT : OP_POP;
        end else begin
            op_o = OP_IDLE;
        end
    end
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             wr_en_o,
    output logic             rd_en_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o,
    output logic             valid_o
);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    typedef struct packed {
        logic [PTR_W-1:0] sp;
        logic             full;
        logic             empty;
        logic             err;
        logic             valid;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [PTR_W-1:0] sp_inc, sp_dec;

    always_comb begin
        sp_inc       = ctrl_q.sp + PTR_ONE;
        sp_dec       = ctrl_q.sp - PTR_ONE;
        ctrl_d       = ctrl_q;
        ctrl_d.err   = 1'b0;
        ctrl_d.valid = 1'b0;
        case (op_i)
            OP_PUSH: begin
                ctrl_d.sp    = sp_inc;
                ctrl_d.empty = 1'b0;
                if (sp_inc == PTR_ZERO) begin
                    ctrl_d.full = 1'b1;
                end
            end
            OP_POP: begin
                ctrl_d.sp    = sp_dec;
                ctrl_d.full  = 1'b0;
                ctrl_d.valid = 1'b1;
                if (sp_dec == PTR_ZERO) begin
                    ctrl_d.empty = 1'b1;
                end
            end
            OP_REJECT: begin
                ctrl_d.err = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.sp    <= PTR_ZERO;
            ctrl_q.full  <= 1'b0;
            ctrl_q.empty <= 1'b1;
            ctrl_q.err   <= 1'b0;
            ctrl_q.valid <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sp_o      = ctrl_q.sp;
    assign wr_addr_o = sp_inc;
    assign wr_en_o   = (op_i == OP_PUSH);
    assign rd_en_o   = (op_i == OP_POP);
    assign full_o    = ctrl_q.full;
    assign empty_o   = ctrl_q.empty;
    assign err_o     = ctrl_q.err;
    assign valid_o   = ctrl_q.valid;
endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    always_comb begin
        rd_d = rd_en_i ? mem_q[rd_addr_i] : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/reg_stack.sv
module reg_stack
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic [DATA_W-1:0]        data_o,
    output logic                     data_valid_o,
    output logic [$clog2(DEPTH)-1:0] sp_o,
    output logic                     full_o,
    output logic                     empty_o,
    output logic                     error_o
);
    localparam int PTR_W = $clog2(DEPTH);

    stk_op_e          op;
    logic [PTR_W-1:0] wr_addr;
    logic             wr_en, rd_en;

    rstk_decode u_decode (
        .push_i  (push_i),
        .pop_i   (pop_i),
        .full_i  (full_o),
        .empty_i (empty_o),
        .op_o    (op)
    );

    rstk_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .sp_o      (sp_o),
        .wr_addr_o (wr_addr),
        .wr_en_o   (wr_en),
        .rd_en_o   (rd_en),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (error_o),
        .valid_o   (data_valid_o)
    );

    rstk_store #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (data_i),
        .rd_en_i   (rd_en),
        .rd_addr_i (sp_o),
        .rd_data_o (data_o)
    );
endmodule

// File: rtl/reg_stack_chk.sv
module reg_stack_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic             data_valid_o,
    input logic [PTR_W-1:0] sp_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             error_o
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_o == '0) && empty_o && !full_o && !error_o && !data_valid_o);

    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + 1'b1) && !empty_o && !error_o);

    p_full_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (sp_o == '0) && !empty_o);

    p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (sp_o == $past(sp_o) - 1'b1) && !full_o && data_valid_o);

    p_empty_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (sp_o == '0));

    p_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> error_o && full_o && $stable(sp_o));

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> error_o && empty_o && !data_valid_o && $stable(sp_o));

    p_both_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> error_o && !data_valid_o && $stable(sp_o)
                              && $stable(full_o) && $stable(empty_o));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(error_o && data_valid_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> !error_o && !data_valid_o);
endmodule

bind reg_stack reg_stack_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .data_valid_o (data_valid_o),
    .sp_o         (sp_o),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .error_o      (error_o)
);

// File: tb/reg_stack_bench.sv
`timescale 1ns/1ps
module reg_stack_bench;
    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int PW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [DW-1:0] data_o;
    logic          data_valid_o;
    logic [PW-1:0] sp_o;
    logic          full_o, empty_o, error_o;

    int n_chk = 0;
    int n_bad = 0;

    // independent model of the stack contents
    logic [DW-1:0] mdl [DEPTH];
    int            cnt = 0;
    logic [DW-1:0] last_pop = '0;

    always #2.5 clk = ~clk;

    reg_stack #(.DATA_W(DW), .DEPTH(DEPTH)) u_reg_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_i),
        .pop_i        (pop_i),
        .data_i       (data_i),
        .data_o       (data_o),
        .data_valid_o (data_valid_o),
        .sp_o         (sp_o),
        .full_o       (full_o),
        .empty_o      (empty_o),
        .error_o      (error_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, then sample every output at the next falling edge
    task automatic step(input logic p, input logic q, input logic [DW-1:0] v, input string req);
        logic exp_err, exp_val;
        logic [DW-1:0] exp_data;
        exp_err = 1'b0;
        exp_val = 1'b0;
        exp_data = last_pop;
        if ((p && q) || (p && cnt == DEPTH) || (q && cnt == 0)) begin
            exp_err = 1'b1;
        end else if (p) begin
            mdl[cnt] = v;
            cnt++;
        end else if (q) begin
            cnt--;
            exp_data = mdl[cnt];
            exp_val = 1'b1;
        end
        push_i = p;
        pop_i  = q;
        data_i = v;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        check(req, "sp_o", int'(sp_o), cnt % DEPTH);
        check(req, "full_o", int'(full_o), int'(cnt == DEPTH));
        check(req, "empty_o", int'(empty_o), int'(cnt == 0));
        check(req, "error_o", int'(error_o), int'(exp_err));
        check(req, "data_valid_o", int'(data_valid_o), int'(exp_val));
        check(req, "data_o", int'(data_o), int'(exp_data));
        last_pop = exp_data;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cnt = 0;
        last_pop = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "sp_o", int'(sp_o), 0);
        check("R1", "empty_o", int'(empty_o), 1);
        check("R1", "full_o", int'(full_o), 0);
        check("R1", "error_o", int'(error_o), 0);
        check("R1", "data_valid_o", int'(data_valid_o), 0);
    endtask

    task automatic t_small_lifo();
        step(1'b1, 1'b0, 8'h3C, "R2");
        step(1'b1, 1'b0, 8'hA5, "R2");
        step(1'b1, 1'b0, 8'h71, "R2");
        step(1'b0, 1'b0, 8'h00, "R10");
        step(1'b0, 1'b1, 8'h00, "R4");
        step(1'b0, 1'b1, 8'h00, "R6");
        step(1'b0, 1'b0, 8'hFF, "R10");
        step(1'b0, 1'b1, 8'h00, "R5");
    endtask

    task automatic t_pop_empty();
        step(1'b0, 1'b1, 8'h00, "R8");
        step(1'b0, 1'b1, 8'h00, "R8");
        step(1'b0, 1'b0, 8'h00, "R10");
    endtask

    task automatic t_both();
        step(1'b1, 1'b1, 8'h11, "R9");
        step(1'b1, 1'b0, 8'h5A, "R2");
        step(1'b1, 1'b0, 8'hC3, "R2");
        step(1'b1, 1'b1, 8'hEE, "R9");
        step(1'b0, 1'b1, 8'h00, "R9");
        step(1'b0, 1'b1, 8'h00, "R9");
    endtask

    task automatic t_fill_wrap();
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, DW'(i * 37 + 5), (i == DEPTH - 1) ? "R3" : "R2");
        end
        step(1'b1, 1'b0, 8'hDD, "R7");
        step(1'b1, 1'b1, 8'hBB, "R9");
        step(1'b0, 1'b0, 8'h00, "R10");
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b1, 8'h00, (i == 0) ? "R4" : ((i == DEPTH - 1) ? "R5" : "R6"));
        end
        step(1'b0, 1'b1, 8'h00, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_small_lifo();
        t_pop_empty();
        t_both();
        t_fill_wrap();
        t_reset();
        t_small_lifo();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule